// File: doc/BRIEF.md
# In-Order Load Return Sequencer

This block sits between a load issue stage and the integer register file write port. Each accepted load enters a small circular tracking queue together with its hit or miss status and a per-load countdown. Results leave through a single writeback port, strictly oldest first. A younger load that hits therefore waits behind an older load that missed until the older one's fill arrives.

The return latency of a hit depends on the operand. Unsigned loads and all doubleword loads take the short latency (two edges). Signed byte, halfword and word loads take the long latency (three edges). Once a long-latency load is accepted, any load accepted on the very next edge also takes the long latency, and this chain continues for as long as loads keep arriving on back-to-back edges. A load whose byte offset is not aligned to its size is reported on a trap port instead of entering the queue. Cache arrays and the fill path are outside the block: the fill path reports a completed miss by presenting the tag of that load.

Top module: `in_order_load_ret`

## Requirements
- R1: An aligned unsigned hit, or any doubleword hit (size code 3), that reaches an idle return path raises `wb_valid` with its tag in the cycle that follows the second rising edge after the edge that accepted it.
- R2: A signed hit of size code 0 (byte), 1 (halfword) or 2 (word) returns one edge later than R1, at the third edge after acceptance. A signed doubleword (code 3) keeps the R1 timing.
- R3: A load accepted on the edge right after a long-latency load also uses the long latency, and the effect chains. A cycle with no accepted load, or with a trapped load, ends the chain.
- R4: A miss returns on the edge after its tag is presented on `fill_valid`/`fill_tag`. Returns occur in acceptance order, so younger hits are held behind an older pending miss.
- R5: At most one result is written back per cycle, and `wb_valid` is never high unless a queued load is due under R1 to R4.
- R6: A load is misaligned when its offset has a nonzero bit among the low bits its size covers: bit 0 for a halfword, bits 1:0 for a word, bits 2:0 for a doubleword. A byte is never misaligned. A misaligned load that is accepted raises `trap_valid` with its tag on the next edge. It produces no writeback and takes no queue slot.
- R7: `issue_ready` is low exactly while DEPTH loads are outstanding. A load presented while it is low is not accepted.
- R8: While reset is asserted, `wb_valid` and `trap_valid` are low and `issue_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | A load is presented |
| issue_ready | output | 1 | Tracking queue can accept a load |
| issue_tag | input | TAG_W | Destination tag of the load |
| issue_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| issue_signed | input | 1 | Sign-extending load |
| issue_offset | input | 3 | Low three address bits of the load |
| issue_hit | input | 1 | Cache lookup hit for this load |
| fill_valid | input | 1 | A pending miss has been filled |
| fill_tag | input | TAG_W | Tag of the filled load |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_tag | output | TAG_W | Tag of the returned load |
| trap_valid | output | 1 | A misaligned load was rejected |
| trap_tag | output | TAG_W | Tag of the rejected load |

## Verification
A misaligned rejection and an in-order writeback can be reported in the same cycle, because one comes from the issue side and the other from the queue head. The random phase mixes misaligned offsets into dense traffic that is waiting behind misses, which makes the two coincide often. A fill and a new issue also land on the same edge regularly, with the fill freeing the head while the chaining state changes. Every cycle both output ports are compared against a behavioural queue. That queue is driven only by acceptance edges, fill edges and the latency rules, so any early, late, reordered, missing or extra return shows up at the cycle it happens.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } ld_size_e;

   // nonzero offset bit inside the span covered by the access size
   function automatic logic off_misaligned(ld_size_e sz, logic [2:0] off);
      case (sz)
         SZ_HALF: off_misaligned = off[0];
         SZ_WORD: off_misaligned = |off[1:0];
         SZ_DBL:  off_misaligned = |off;
         default: off_misaligned = 1'b0;
      endcase
   endfunction

   function automatic logic is_narrow_signed(ld_size_e sz, logic sgn);
      is_narrow_signed = sgn && (sz != SZ_DBL);
   endfunction

endpackage

// File: rtl/lrs_align.sv
module lrs_align
   import lrs_pkg::*;
(
   input  ld_size_e   sz,
   input  logic [2:0] off,
   output logic       misaligned
);
   assign misaligned = off_misaligned(sz, off);
endmodule

// File: rtl/lrs_lat_sel.sv
module lrs_lat_sel
   import lrs_pkg::*;
#(
   parameter int HIT_LAT  = 2,
   parameter int SLOW_LAT = 3,
   parameter bit CHAIN    = 1'b1,
   localparam int WW      = $clog2(SLOW_LAT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  ld_size_e      sz,
   input  logic          sgn,
   output logic [WW-1:0] wait_val
);
   logic slow;
   logic chain_on;

   generate
      if (CHAIN) begin : g_chain
         logic dly_mode;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly_mode <= 1'b0;
            else        dly_mode <= push && slow;
         end
         assign chain_on = dly_mode;
      end else begin : g_nochain
         assign chain_on = 1'b0;
      end
   endgenerate

   assign slow     = is_narrow_signed(sz, sgn) || chain_on;
   assign wait_val = slow ? WW'(SLOW_LAT) : WW'(HIT_LAT);
endmodule

// File: rtl/lrs_queue.sv
module lrs_queue #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 4,
   parameter int WW     = 2,
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [TAG_W-1:0] push_tag,
   input  logic             push_hit,
   input  logic [WW-1:0]    push_wait,
   input  logic             fill_valid,
   input  logic [TAG_W-1:0] fill_tag,
   output logic             full,
   output logic             head_fire,
   output logic [TAG_W-1:0] head_tag
);
   logic             vld [DEPTH];
   logic             fld [DEPTH];
   logic [WW-1:0]    wt  [DEPTH];
   logic [TAG_W-1:0] tg  [DEPTH];
   logic [PW-1:0]    hd, tl;
   logic [PW:0]      cnt;

   assign full      = (cnt == (PW+1)'(DEPTH));
   assign head_fire = vld[hd] && fld[hd] && (wt[hd] <= WW'(1));
   assign head_tag  = tg[hd];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hd  <= '0;
         tl  <= '0;
         cnt <= '0;
      end else begin
         if (head_fire) hd <= hd + PW'(1);
         if (push)      tl <= tl + PW'(1);
         cnt <= cnt + {{PW{1'b0}}, push} - {{PW{1'b0}}, head_fire};
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld[i] <= 1'b0;
               fld[i] <= 1'b0;
               wt[i]  <= '0;
               tg[i]  <= '0;
            end else if (push && (tl == PW'(i))) begin
               vld[i] <= 1'b1;
               fld[i] <= push_hit;
               wt[i]  <= push_wait;
               tg[i]  <= push_tag;
            end else begin
               if (head_fire && (hd == PW'(i))) vld[i] <= 1'b0;
               if (vld[i] && !fld[i] && fill_valid && (fill_tag == tg[i])) begin
                  fld[i] <= 1'b1;
                  wt[i]  <= WW'(1);
               end else if (wt[i] != '0) begin
                  wt[i] <= wt[i] - WW'(1);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/in_order_load_ret.sv
module in_order_load_ret
   import lrs_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int TAG_W    = 4,
   parameter int HIT_LAT  = 2,
   parameter int SLOW_LAT = 3,
   parameter bit CHAIN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_valid,
   output logic             issue_ready,
   input  logic [TAG_W-1:0] issue_tag,
   input  logic [1:0]       issue_size,
   input  logic             issue_signed,
   input  logic [2:0]       issue_offset,
   input  logic             issue_hit,
   input  logic             fill_valid,
   input  logic [TAG_W-1:0] fill_tag,
   output logic             wb_valid,
   output logic [TAG_W-1:0] wb_tag,
   output logic             trap_valid,
   output logic [TAG_W-1:0] trap_tag
);
   localparam int WW = $clog2(SLOW_LAT + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (HIT_LAT < 1 || SLOW_LAT <= HIT_LAT) begin : g_bad_lat
         $error("latencies need 1 <= HIT_LAT < SLOW_LAT");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("TAG_W must be positive");
      end
   endgenerate

   ld_size_e         sz;
   logic             mis, take, push, full, head_fire;
   logic [WW-1:0]    wait_val;
   logic [TAG_W-1:0] head_tag;

   assign sz          = ld_size_e'(issue_size);
   assign issue_ready = !full;
   assign take        = issue_valid && issue_ready;
   assign push        = take && !mis;

   lrs_align u_align (
      .sz         (sz),
      .off        (issue_offset),
      .misaligned (mis)
   );

   lrs_lat_sel #(
      .HIT_LAT  (HIT_LAT),
      .SLOW_LAT (SLOW_LAT),
      .CHAIN    (CHAIN)
   ) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .sz       (sz),
      .sgn      (issue_signed),
      .wait_val (wait_val)
   );

   lrs_queue #(
      .DEPTH (DEPTH),
      .TAG_W (TAG_W),
      .WW    (WW)
   ) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .push_tag   (issue_tag),
      .push_hit   (issue_hit),
      .push_wait  (wait_val),
      .fill_valid (fill_valid),
      .fill_tag   (fill_tag),
      .full       (full),
      .head_fire  (head_fire),
      .head_tag   (head_tag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid   <= 1'b0;
         wb_tag     <= '0;
         trap_valid <= 1'b0;
         trap_tag   <= '0;
      end else begin
         wb_valid   <= head_fire;
         wb_tag     <= head_tag;
         trap_valid <= take && mis;
         trap_tag   <= issue_tag;
      end
   end
endmodule

// File: rtl/lrs_sva.sv
module lrs_sva
   import lrs_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int OW   = $clog2(DEPTH) + 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       issue_valid,
   input logic       issue_ready,
   input logic [1:0] issue_size,
   input logic [2:0] issue_offset,
   input logic       wb_valid,
   input logic       trap_valid
);
   logic          mis_c, push_c;
   logic [OW-1:0] occ, live;

   assign mis_c  = off_misaligned(ld_size_e'(issue_size), issue_offset);
   assign push_c = issue_valid && issue_ready && !mis_c;
   assign live   = occ - {{(OW-1){1'b0}}, wb_valid};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + {{(OW-1){1'b0}}, push_c} - {{(OW-1){1'b0}}, wb_valid};
   end

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live <= OW'(DEPTH));
   // R7
   full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live == OW'(DEPTH)) |-> !issue_ready);
   // R5
   wb_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (occ != '0));
   // R6
   trap_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready && mis_c) |=> trap_valid);
   // R6
   trap_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> $past(issue_valid && issue_ready));
endmodule

bind in_order_load_ret lrs_sva #(.DEPTH(DEPTH)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .issue_valid  (issue_valid),
   .issue_ready  (issue_ready),
   .issue_size   (issue_size),
   .issue_offset (issue_offset),
   .wb_valid     (wb_valid),
   .trap_valid   (trap_valid)
);

// File: tb/tb_in_order_load_ret.sv
module tb_in_order_load_ret;
   localparam int DEPTH = 8;
   localparam int TAG_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             issue_valid = 1'b0;
   logic             issue_ready;
   logic [TAG_W-1:0] issue_tag = '0;
   logic [1:0]       issue_size = '0;
   logic             issue_signed = 1'b0;
   logic [2:0]       issue_offset = '0;
   logic             issue_hit = 1'b0;
   logic             fill_valid = 1'b0;
   logic [TAG_W-1:0] fill_tag = '0;
   logic             wb_valid;
   logic [TAG_W-1:0] wb_tag;
   logic             trap_valid;
   logic [TAG_W-1:0] trap_tag;

   in_order_load_ret #(.DEPTH(DEPTH), .TAG_W(TAG_W)) dut (.*);

   always #10 clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit in_reset = 1'b1;
   bit done = 1'b0;

   // behavioural queue, ring indexed by sequence number
   int m_tag [64], m_rdy [64], m_plan [64];
   bit m_miss [64], m_filled [64];
   string m_req [64];
   int mh = 0, mt = 0;
   bit chain = 1'b0;
   int trap_edge = -1, trap_exp_tag = 0;
   int next_tag = 0;

   always @(posedge clk) cyc = cyc + 1;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
      end
   endtask

   function automatic bit ref_mis(int sz, int off);
      return (off & ((1 << sz) - 1)) != 0;
   endfunction

   function automatic bit tag_busy(int t);
      for (int s = mh; s < mt; s++) if (m_tag[s % 64] == t) return 1'b1;
      return 1'b0;
   endfunction

   int k, n, lat;
   bit exp_wb, exp_tr, slow, nsg, sent;
   string rq;

   always @(negedge clk) begin
      if (in_reset) begin
         // R8
         chk(wb_valid == 1'b0, "R8", "wb_valid in reset", wb_valid, 0);
         chk(trap_valid == 1'b0, "R8", "trap_valid in reset", trap_valid, 0);
         chk(issue_ready == 1'b1, "R8", "issue_ready in reset", issue_ready, 1);
      end else begin
         n = cyc;
         exp_wb = 1'b0;
         rq = "R5";
         if (mh != mt) begin
            k = mh % 64;
            if (m_rdy[k] >= 0 && m_rdy[k] <= n) begin
               exp_wb = 1'b1;
               rq = m_req[k];
            end
         end
         chk(wb_valid == exp_wb, rq, "wb_valid", wb_valid, exp_wb);
         if (exp_wb) begin
            chk(wb_tag == TAG_W'(m_tag[mh % 64]), rq, "wb_tag", wb_tag, m_tag[mh % 64]);
            mh++;
         end
         exp_tr = (trap_edge == n);
         chk(trap_valid == exp_tr, "R6", "trap_valid", trap_valid, exp_tr);
         if (exp_tr) chk(trap_tag == TAG_W'(trap_exp_tag), "R6", "trap_tag", trap_tag, trap_exp_tag);
         chk(issue_ready == ((mt - mh) < DEPTH), "R7", "issue_ready", issue_ready, (mt - mh) < DEPTH);

         // record the load that the next edge will accept
         if (issue_valid && issue_ready) begin
            if (ref_mis(int'(issue_size), int'(issue_offset))) begin
               trap_edge = n + 1;
               trap_exp_tag = int'(issue_tag);
               chain = 1'b0;
            end else begin
               nsg  = issue_signed && issue_size != 2'd3;
               slow = nsg || chain;
               lat  = slow ? 3 : 2;
               k = mt % 64;
               m_tag[k]    = int'(issue_tag);
               m_miss[k]   = !issue_hit;
               m_filled[k] = issue_hit;
               m_rdy[k]    = issue_hit ? n + 1 + lat : -1;
               m_plan[k]   = n + 9 + int'($urandom % 3);
               m_req[k]    = !issue_hit ? "R4" : nsg ? "R2" : chain ? "R3" :
                             issue_signed ? "R2" : "R1";
               chain = slow;
               mt++;
            end
         end else begin
            chain = 1'b0;
         end

         // fill the oldest due miss, one per cycle
         fill_valid <= 1'b0;
         sent = 1'b0;
         for (int s = mh; s < mt; s++) begin
            if (!sent && m_miss[s % 64] && !m_filled[s % 64] && m_plan[s % 64] <= n + 1) begin
               m_filled[s % 64] = 1'b1;
               m_rdy[s % 64] = n + 2;
               fill_valid <= 1'b1;
               fill_tag   <= TAG_W'(m_tag[s % 64]);
               sent = 1'b1;
            end
         end
      end
   end

   // called at posedge + 5 ns; returns there with issue_valid low
   task automatic iss(int sz, bit sgn, int off, bit hit);
      bit ok;
      while (tag_busy(next_tag)) next_tag = (next_tag + 1) % (1 << TAG_W);
      issue_valid  = 1'b1;
      issue_tag    = TAG_W'(next_tag);
      issue_size   = 2'(sz);
      issue_signed = sgn;
      issue_offset = 3'(off);
      issue_hit    = hit;
      next_tag = (next_tag + 1) % (1 << TAG_W);
      do begin
         @(negedge clk);
         ok = issue_ready;
         @(posedge clk);
         #5;
      end while (!ok);
      issue_valid = 1'b0;
   endtask

   task automatic idle(int c);
      issue_valid = 1'b0;
      repeat (c) begin
         @(posedge clk);
         #5;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd1234);
      repeat (3) @(posedge clk);
      #5;
      rst_n = 1'b1;
      in_reset = 1'b0;
      idle(2);
      // R1: unsigned word hit, two edges
      iss(2, 0, 0, 1); idle(6);
      // R2: signed byte is slow, signed doubleword is not
      iss(0, 1, 3, 1); idle(6);
      iss(3, 1, 0, 1); idle(6);
      // R3: chain behind a signed halfword, broken by a gap
      iss(1, 1, 2, 1); iss(2, 0, 4, 1); iss(2, 0, 0, 1); iss(3, 0, 0, 1);
      idle(1); iss(2, 0, 0, 1); idle(6);
      // R3/R6: a trapped load breaks the chain
      iss(0, 1, 1, 1); iss(2, 0, 2, 1); iss(2, 0, 0, 1); idle(6);
      // R6: every misaligned size
      iss(1, 0, 1, 1); iss(2, 1, 6, 1); iss(3, 0, 4, 1); iss(0, 0, 7, 1); idle(6);
      // R4: miss holds younger hits
      iss(3, 0, 0, 0); iss(2, 0, 0, 1); iss(0, 1, 5, 1); iss(1, 0, 2, 1); idle(20);
      // R7: fill the queue with misses
      for (int i = 0; i < DEPTH + 2; i++) iss(2, 0, 0, 0);
      idle(40);
      // random traffic
      for (int i = 0; i < 2500; i++) begin
         int sz  = int'($urandom % 4);
         int off = ($urandom % 10 == 0) ? int'($urandom % 8) : (int'($urandom % 8) & ~((1 << sz) - 1));
         iss(sz, 1'($urandom % 2), off, ($urandom % 10) < 7);
         if ($urandom % 4 == 0) idle(int'($urandom % 3));
      end
      idle(60);
      // R4: everything issued has been returned
      chk(mh == mt, "R4", "outstanding at end", mt - mh, 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule